// File: doc/BRIEF.md
# Two-Wire Controller Status and Interrupt Registers

This block is the register front end of a two-wire serial bus controller. It holds the controller's setup registers, a sticky event status register, an interrupt enable register and a transfer-in-progress register, all reached through a plain 32-bit word port with byte offsets. The transfer engine is not part of the block. In its place, five single-cycle event inputs report that a transfer is done, that arbitration was lost, that the target did not respond, that a data collision happened, or that the bus was busy.

Each event sets its own status bit, and that bit stays set until software writes a one to it. The done event has its own bit, apart from the error events. Software can therefore enable only the done interrupt, take one interrupt per transfer, and still read every error flag from the status register. The block also decodes the status bits into a single prioritised result code. A two-state machine tracks whether a transfer is running. A write to the command offset moves it from IDLE to ACTIVE, and the done event moves it from ACTIVE back to IDLE.

Top module: `twi_stat_regs`

## Requirements
- R1: After reset, the status, interrupt enable, busy, command, address and both data registers read 0. The configuration register reads 0x00003302. Both clock registers read 0x0000301F.
- R2: A one on evt_pulse sets the status bit at the same position in the cycle after the pulse. The positions are bit 0 done, bit 1 lost arbitration, bit 2 no response, bit 3 data collision and bit 4 bus busy. The status register is read at offset 0x1C, bits 4:0, and each set bit stays set until it is cleared.
- R3: A write to 0x1C clears each status bit whose data bit is one and leaves the bits written with zero unchanged. If an event pulse arrives in the same cycle as a clear of the same bit, the bit stays set.
- R4: The interrupt enable register at 0x20 holds bits 4:0, with the same layout as the status register. irq is high exactly when some status bit and its enable bit are both set. With the enable register at zero, irq stays low.
- R5: The busy register at 0x24 reads 1 in bit 0 from the cycle after a write to the command offset 0x0C until the cycle after a done event, and reads 0 otherwise. A command write in the same cycle as a done event leaves it at 1.
- R6: result reports, with falling priority, 1 when lost arbitration is set, 2 when no response is set, 3 when data collision is set, and 4 when bus busy is set. It reports 0 when none of these four is set, whatever the done bit holds.
- R7: Writes land in the register at the written offset, and reads return them with reserved bits at zero. The offsets and their kept bits are: 0x00 and 0x04 clock (mask 0xF3FF), 0x08 configuration (mask 0xFFF3), 0x0C command (mask 0x0377), 0x10 address (mask 0x03FF), 0x14 and 0x18 data (all 32 bits).
- R8: Reads from an offset outside the map, including a misaligned offset, return 0, and writes to such an offset change nothing. A write to the busy register has no effect on the value it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for bus_addr and bus_wdata |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| evt_pulse | input | 5 | Event pulses: done, lost arbitration, no response, data collision, bus busy |
| irq | output | 1 | Interrupt request, level |
| result | output | 3 | Prioritised transfer result code |

## Verification
Two pairs of actions can land in the same cycle. The first is an event pulse together with a software clear of the same status bit. The second is a done event together with a write to the command offset. The bench drives each pair on purpose at fixed points, and also lets them meet often during a long stretch of random writes and events. A behavioural reference model, updated on every clock, settles the expected outcome: the event keeps the bit set, and the new command keeps busy at 1. The model is compared with irq, result and the read data of the addressed register on every cycle.

// File: rtl/twi_stat_pkg.sv
package twi_stat_pkg;

    localparam int NUM_EVT = 5;
    localparam int NUM_CFG = 7;

    localparam int EVT_DONE      = 0;
    localparam int EVT_LOST_ARB  = 1;
    localparam int EVT_NO_RESP   = 2;
    localparam int EVT_COLLISION = 3;
    localparam int EVT_BUS_BUSY  = 4;

    localparam logic [7:0] OFF_CMD  = 8'h0C;
    localparam logic [7:0] OFF_STS  = 8'h1C;
    localparam logic [7:0] OFF_MSK  = 8'h20;
    localparam logic [7:0] OFF_BUSY = 8'h24;

    // plain setup registers: offset, reset value, writable bits
    localparam logic [7:0] CFG_OFF [NUM_CFG] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18};
    localparam logic [31:0] CFG_RST [NUM_CFG] = '{32'h301F, 32'h301F, 32'h3302, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic [31:0] CFG_MSK [NUM_CFG] = '{32'hF3FF, 32'hF3FF, 32'hFFF3, 32'h0377, 32'h03FF,
                                                 32'hFFFF_FFFF, 32'hFFFF_FFFF};

    typedef enum logic [2:0] {
        RES_OK        = 3'd0,
        RES_LOST_ARB  = 3'd1,
        RES_NO_RESP   = 3'd2,
        RES_COLLISION = 3'd3,
        RES_BUS_BUSY  = 3'd4
    } twi_res_e;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } twi_xfer_st_e;

endpackage

// File: rtl/twi_mask_reg.sv
module twi_mask_reg #(
    parameter int          W       = 32,
    parameter logic [31:0] RST_VAL = 32'h0,
    parameter logic [31:0] KEEP    = 32'hFFFF_FFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] RST_W  = RST_VAL[W-1:0];
    localparam logic [W-1:0] KEEP_W = KEEP[W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RST_W & KEEP_W;
        else if (wr_en)
            q <= wdata & KEEP_W;
    end
endmodule

// File: rtl/twi_evt_bank.sv
module twi_evt_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] evt,
    output logic [N-1:0] sts_q
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sts_q[b] <= 1'b0;
            else if (evt[b])
                sts_q[b] <= 1'b1;          // event beats a same-cycle clear
            else if (clr_en && clr_bits[b])
                sts_q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/twi_busy_fsm.sv
module twi_busy_fsm
    import twi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic done_evt,
    output logic busy
);
    twi_xfer_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_wr) state_d = ST_ACTIVE;
            ST_ACTIVE: if (!cmd_wr && done_evt) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == ST_ACTIVE);
    end
endmodule

// File: rtl/twi_result_dec.sv
module twi_result_dec
    import twi_stat_pkg::*;
#(
    parameter int N = 5
) (
    input  logic [N-1:0] sts,
    output logic [2:0]   code
);
    always_comb begin
        if (sts[EVT_LOST_ARB])       code = RES_LOST_ARB;
        else if (sts[EVT_NO_RESP])   code = RES_NO_RESP;
        else if (sts[EVT_COLLISION]) code = RES_COLLISION;
        else if (sts[EVT_BUS_BUSY])  code = RES_BUS_BUSY;
        else                         code = RES_OK;
    end
endmodule

// File: rtl/twi_stat_regs.sv
module twi_stat_regs
    import twi_stat_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic              irq,
    output logic [2:0]        result
);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFF_STS);
    localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFF_MSK);
    localparam logic [ADDR_W-1:0] A_BUSY = ADDR_W'(OFF_BUSY);

    logic [DATA_W-1:0]  cfg_q [NUM_CFG];
    logic [NUM_EVT-1:0] sts_q;
    logic [NUM_EVT-1:0] msk_q;
    logic               busy;

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        twi_mask_reg #(
            .W       (DATA_W),
            .RST_VAL (CFG_RST[i]),
            .KEEP    (CFG_MSK[i])
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr && (bus_addr == ADDR_W'(CFG_OFF[i]))),
            .wdata (bus_wdata),
            .q     (cfg_q[i])
        );
    end

    twi_mask_reg #(
        .W       (NUM_EVT),
        .RST_VAL (32'h0),
        .KEEP    (32'h1F)
    ) u_msk (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && (bus_addr == A_MSK)),
        .wdata (bus_wdata[NUM_EVT-1:0]),
        .q     (msk_q)
    );

    twi_evt_bank #(.N(NUM_EVT)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (bus_wr && (bus_addr == A_STS)),
        .clr_bits (bus_wdata[NUM_EVT-1:0]),
        .evt      (evt_pulse),
        .sts_q    (sts_q)
    );

    twi_busy_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (bus_wr && (bus_addr == A_CMD)),
        .done_evt (evt_pulse[EVT_DONE]),
        .busy     (busy)
    );

    twi_result_dec #(.N(NUM_EVT)) u_dec (
        .sts  (sts_q),
        .code (result)
    );

    assign irq = |(sts_q & msk_q);

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (bus_addr == ADDR_W'(CFG_OFF[i]))
                bus_rdata = cfg_q[i];
        if (bus_addr == A_STS)  bus_rdata = DATA_W'(sts_q);
        if (bus_addr == A_MSK)  bus_rdata = DATA_W'(msk_q);
        if (bus_addr == A_BUSY) bus_rdata = DATA_W'(busy);
    end
endmodule

// File: rtl/twi_stat_chk.sv
module twi_stat_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [4:0]        bus_wlow,
    input logic [4:0]        evt_pulse,
    input logic [4:0]        sts_q,
    input logic [4:0]        msk_q,
    input logic              busy,
    input logic              irq
);
    AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((sts_q & $past(evt_pulse)) == $past(evt_pulse))); // R2

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && evt_pulse == 5'd0) |=> $stable(sts_q)); // R2

    AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8'h1C) && bus_wlow[0] && !evt_pulse[0]) |=> !sts_q[0]); // R3

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq); // R4

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q == 5'd0) |-> !irq); // R4

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse[0] && !(bus_wr && bus_addr == ADDR_W'(8'h0C))) |=> !busy); // R5

    AST_CMD_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8'h0C)) |=> busy); // R5
endmodule

bind twi_stat_regs twi_stat_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wlow  (bus_wdata[4:0]),
    .evt_pulse (evt_pulse),
    .sts_q     (sts_q),
    .msk_q     (msk_q),
    .busy      (busy),
    .irq       (irq)
);

// File: tb/twi_stat_regs_tb_top.sv
`timescale 1ns/1ps
module twi_stat_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [4:0]  evt_pulse = 5'h0;
    logic        irq;
    logic [2:0]  result;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    int unsigned m_clk0, m_clk1, m_cfg, m_cmd, m_adr, m_d0, m_d1;
    int unsigned m_sts, m_msk, m_busy;

    always #4 clk = ~clk;

    twi_stat_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .irq(irq), .result(result)
    );

    task automatic m_reset();
        m_clk0 = 32'h301F; m_clk1 = 32'h301F; m_cfg = 32'h3302;
        m_cmd = 0; m_adr = 0; m_d0 = 0; m_d1 = 0;
        m_sts = 0; m_msk = 0; m_busy = 0;
    endtask

    function automatic int unsigned m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_clk0;
            8'h04: return m_clk1;
            8'h08: return m_cfg;
            8'h0C: return m_cmd;
            8'h10: return m_adr;
            8'h14: return m_d0;
            8'h18: return m_d1;
            8'h1C: return m_sts;
            8'h20: return m_msk;
            8'h24: return m_busy;
            default: return 0;
        endcase
    endfunction

    function automatic string r_tag(input logic [7:0] a);
        if (a == 8'h1C) return "R2/R3";
        if (a == 8'h20) return "R4";
        if (a == 8'h24) return "R5";
        if (a <= 8'h18 && a[1:0] == 2'b00) return "R7";
        return "R8";
    endfunction

    function automatic int unsigned m_result();
        if (m_sts[1]) return 1;
        if (m_sts[2]) return 2;
        if (m_sts[3]) return 3;
        if (m_sts[4]) return 4;
        return 0;
    endfunction

    task automatic m_update(input bit wr, input logic [7:0] a, input logic [31:0] wd, input logic [4:0] ev);
        int unsigned nb;
        nb = m_busy;
        if (wr) begin
            case (a)
                8'h00: m_clk0 = wd & 32'hF3FF;
                8'h04: m_clk1 = wd & 32'hF3FF;
                8'h08: m_cfg  = wd & 32'hFFF3;
                8'h0C: m_cmd  = wd & 32'h0377;
                8'h10: m_adr  = wd & 32'h03FF;
                8'h14: m_d0   = wd;
                8'h18: m_d1   = wd;
                8'h1C: m_sts  = m_sts & ~(wd & 32'h1F);
                8'h20: m_msk  = wd & 32'h1F;
                default: ;
            endcase
        end
        m_sts = m_sts | ev;
        if (wr && a == 8'h0C) nb = 1;
        else if (ev[0]) nb = 0;
        m_busy = nb;
    endtask

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive, compare against model, clock, update model
    task automatic tick(input bit wr, input logic [7:0] a, input logic [31:0] wd, input logic [4:0] ev);
        bus_wr = wr; bus_addr = a; bus_wdata = wd; evt_pulse = ev;
        #1;
        chk("R4 irq", 32'(irq), ((m_sts & m_msk) != 0) ? 1 : 0);
        chk("R6 result", 32'(result), m_result());
        chk({r_tag(a), " rdata"}, bus_rdata, m_read(a));
        @(posedge clk);
        m_update(wr, a, wd, ev);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a);
        tick(1'b0, a, 32'h0, 5'h0);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values read through the port
        bus_addr = 8'h08; #1; chk("R1 cfg reset", bus_rdata, 32'h3302);
        bus_addr = 8'h00; #1; chk("R1 clk0 reset", bus_rdata, 32'h301F);
        bus_addr = 8'h04; #1; chk("R1 clk1 reset", bus_rdata, 32'h301F);
        bus_addr = 8'h1C; #1; chk("R1 status reset", bus_rdata, 0);
        bus_addr = 8'h24; #1; chk("R1 busy reset", bus_rdata, 0);
        chk("R1 irq reset", 32'(irq), 0);
        for (int a = 0; a <= 8'h28; a += 4) rd(8'(a));

        // R7: full-ones and pattern write/readback
        for (int a = 0; a <= 8'h18; a += 4) begin
            tick(1'b1, 8'(a), 32'hFFFF_FFFF, 5'h0);
            rd(8'(a));
            tick(1'b1, 8'(a), 32'hA5C3_5A3C, 5'h0);
            rd(8'(a));
        end

        // R8: unmapped and misaligned writes leave everything alone
        tick(1'b1, 8'h28, 32'hFFFF_FFFF, 5'h0);
        tick(1'b1, 8'h1D, 32'hFFFF_FFFF, 5'h0);
        tick(1'b1, 8'h24, 32'hFFFF_FFFF, 5'h0);
        for (int a = 0; a <= 8'h2C; a += 4) rd(8'(a));
        rd(8'h1D);

        // R2 / R4: each event alone with all enables on
        tick(1'b1, 8'h20, 32'h1F, 5'h0);
        for (int b = 0; b < 5; b++) begin
            tick(1'b0, 8'h1C, 0, 5'(1 << b));
            rd(8'h1C);
            tick(1'b1, 8'h1C, 32'h1F, 5'h0);
            rd(8'h1C);
        end

        // R3: partial clear, zeros keep bits, event beats same-cycle clear
        tick(1'b0, 8'h1C, 0, 5'h1F);
        tick(1'b1, 8'h1C, 32'h0, 5'h0);
        tick(1'b1, 8'h1C, 32'h5, 5'h0);
        rd(8'h1C);
        tick(1'b1, 8'h1C, 32'h1F, 5'h0A);
        rd(8'h1C);
        tick(1'b1, 8'h1C, 32'h1F, 5'h0);
        rd(8'h1C);

        // R4: only done enabled, errors latched but no extra irq
        tick(1'b1, 8'h20, 32'h1, 5'h0);
        tick(1'b0, 8'h1C, 0, 5'h0E);
        rd(8'h1C);
        tick(1'b0, 8'h1C, 0, 5'h01);
        rd(8'h1C);
        tick(1'b1, 8'h20, 32'h0, 5'h0);
        rd(8'h20);
        tick(1'b1, 8'h1C, 32'h1F, 5'h0);

        // R6: every status combination
        for (int v = 0; v < 32; v++) begin
            tick(1'b0, 8'h1C, 0, 5'(v));
            rd(8'h1C);
            tick(1'b1, 8'h1C, 32'h1F, 5'h0);
        end

        // R5: busy sequence and command write meeting done
        tick(1'b1, 8'h0C, 32'h0212, 5'h0);
        rd(8'h24);
        rd(8'h24);
        tick(1'b0, 8'h24, 0, 5'h01);
        rd(8'h24);
        tick(1'b1, 8'h0C, 32'h0001, 5'h0);
        tick(1'b1, 8'h0C, 32'h0101, 5'h01);
        rd(8'h24);
        tick(1'b0, 8'h24, 0, 5'h01);
        rd(8'h24);
        tick(1'b1, 8'h0C, 32'h0, 5'h01);
        rd(8'h24);

        // mixed random traffic, collisions included
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            logic [7:0] a;
            r = $urandom;
            a = 8'((r % 12) * 4);
            if (r[20:18] == 3'd0) a = 8'h1C;
            if (r[20:18] == 3'd1) a = 8'h0C;
            tick(r[8], a, $urandom, (r[12:10] == 3'd0) ? 5'($urandom) : 5'h0);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule